// File: doc/BRIEF.md
# UART FIFO Mode Selection Controller

This block holds the configuration bits of a backward-compatible UART that select its operating mode. From those bits it works out the usable depth of the transmit and receive FIFOs. Three bits take part: a FIFO enable bit and a deep-FIFO bit in the FIFO control register, and an enhanced-mode bit in the enhanced feature register. The deep-FIFO bit has a write guard. It only takes a new value when bit 7 of the line control register is 1 at the time of the FIFO control write.

The block also contains the two byte FIFOs. Each has room for 128 entries, but only as many as the decoded depth are usable: 1, 16 or 128. It reports which feature group applies: the legacy 750 group or the enhanced group. The feature logic itself sits elsewhere.

There is no pin that selects the extended 550 variant. That choice is treated as permanently low, so it never enlarges the FIFOs.

Top module: `uart_fifo_mode_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the outputs are as follows.
  - `mode_code` is 0 and `depth` is 1.
  - The line control register reads 0.
  - Both FIFOs are empty and not full, and both overrun flags are 0.
  - Both read-data outputs are 0.
- R2: While the FIFO enable bit (FCR bit 0) is 0, `depth` is 1 and `mode_code` is 0, whatever the other mode bits hold.
- R3: With FCR bit 0 = 1, EFR bit 4 = 0 and FCR bit 5 = 0, `depth` is 16 and `mode_code` is 1.
- R4: FCR bit 5 takes the value of `wr_data[5]` only on an FCR write (`addr` = 2) made while LCR bit 7 is 1. Any other FCR write leaves it unchanged.
- R5: With FCR bit 0 = 1, EFR bit 4 = 0 and FCR bit 5 = 1, `depth` is 128 and `mode_code` is 2.
- R6: With FCR bit 0 = 1 and EFR bit 4 = 1, `depth` is 128 and `mode_code` is 3, whatever the value of FCR bit 5.
- R7: `feat750_en` equals the inverse of EFR bit 4, and `feat_enh_en` equals EFR bit 4.
- R8: A FIFO is full when its occupancy equals `depth`.
  - A push while full is dropped, even if a pop happens in the same cycle.
  - A push while full sets that FIFO's overrun flag, which stays set until reset.
- R9: A pop on an empty FIFO leaves its read data and all of its flags unchanged.
- R10: A change in `depth` empties both FIFOs on the same clock edge at which `depth` changes.
- R11: The line control register is written at `addr` = 3. With `addr` = 3, `rd_data` shows its value. For any other address, including the write-only FCR at `addr` = 2, `rd_data` is 0.
- R12: Each FIFO returns data in push order. The popped byte appears on the read-data output one cycle after the pop.
- R13: A register write (`wr_en` or `efr_wr`) takes effect on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational from addr) |
| efr_wr | input | 1 | Enhanced feature register write strobe |
| efr_data | input | 8 | Enhanced feature register write data |
| tx_push | input | 1 | Transmit FIFO push |
| tx_din | input | 8 | Transmit FIFO push data |
| tx_pop | input | 1 | Transmit FIFO pop |
| tx_dout | output | 8 | Last byte popped from transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full at current depth |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_overrun | output | 1 | Sticky transmit overrun |
| rx_push | input | 1 | Receive FIFO push |
| rx_din | input | 8 | Receive FIFO push data |
| rx_pop | input | 1 | Receive FIFO pop |
| rx_dout | output | 8 | Last byte popped from receive FIFO |
| rx_full | output | 1 | Receive FIFO full at current depth |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_overrun | output | 1 | Sticky receive overrun |
| mode_code | output | 2 | 0 byte, 1 sixteen-deep, 2 legacy deep, 3 enhanced |
| depth | output | 8 | Usable FIFO depth: 1, 16 or 128 |
| feat750_en | output | 1 | Legacy 750 feature group enabled |
| feat_enh_en | output | 1 | Enhanced feature group enabled |

## Verification
The following results are due one edge after their stimulus:
- `mode_code`, `depth`, the feature flags and the FIFO flush all follow a register write at the edge that samples the strobe.
- The full, empty and overrun flags follow a push at the edge that samples it.
- The popped byte appears one edge after the pop.

`rd_data` follows `addr` combinationally. The bench drives every stimulus at a falling edge and holds it across one rising edge. It removes the stimulus at the next falling edge and compares at that point, half a period after the registering edge.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;

    typedef enum logic [1:0] {
        MODE_BYTE   = 2'd0,
        MODE_STD16  = 2'd1,
        MODE_LEGACY = 2'd2,
        MODE_ENH    = 2'd3
    } uart_mode_e;

    function automatic uart_mode_e decode_mode(input logic fifo_en,
                                               input logic deep_sel,
                                               input logic enh);
        if (!fifo_en)      return MODE_BYTE;
        else if (enh)      return MODE_ENH;
        else if (deep_sel) return MODE_LEGACY;
        else               return MODE_STD16;
    endfunction

endpackage

// File: rtl/mode_regs.sv
module mode_regs
    import uart_mode_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int MID_DEPTH = 16,
    parameter int MAX_DEPTH = 128,
    parameter int FCR_ADDR  = 2,
    parameter int LCR_ADDR  = 3,
    localparam int CW       = $clog2(MAX_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              efr_wr,
    input  logic [DATA_W-1:0] efr_data,
    output uart_mode_e        mode,
    output logic [CW-1:0]     depth,
    output logic              flush,
    output logic              feat750_en,
    output logic              feat_enh_en
);

    typedef struct packed {
        logic              fifo_en;
        logic              deep_sel;
        logic              enh;
        logic [DATA_W-1:0] lcr;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [CW-1:0] depth_d;

    function automatic logic [CW-1:0] mode_depth(input uart_mode_e m);
        case (m)
            MODE_BYTE:  return CW'(1);
            MODE_STD16: return CW'(MID_DEPTH);
            default:    return CW'(MAX_DEPTH);
        endcase
    endfunction

    always_comb begin
        regs_d = regs_q;
        if (wr_en && addr == ADDR_W'(FCR_ADDR)) begin
            regs_d.fifo_en = wr_data[0];
            if (regs_q.lcr[DATA_W-1])
                regs_d.deep_sel = wr_data[5];
        end
        if (wr_en && addr == ADDR_W'(LCR_ADDR))
            regs_d.lcr = wr_data;
        if (efr_wr)
            regs_d.enh = efr_data[4];
        depth_d = mode_depth(decode_mode(regs_d.fifo_en, regs_d.deep_sel, regs_d.enh));
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign mode        = decode_mode(regs_q.fifo_en, regs_q.deep_sel, regs_q.enh);
    assign depth       = mode_depth(mode);
    assign flush       = !rst && (depth_d != depth);
    assign feat750_en  = !regs_q.enh;
    assign feat_enh_en = regs_q.enh;
    assign rd_data     = (addr == ADDR_W'(LCR_ADDR)) ? regs_q.lcr : '0;

    AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(FCR_ADDR) && !regs_q.lcr[DATA_W-1]) |=> $stable(regs_q.deep_sel)); // R4
    AST_EFR_TAKE: assert property (@(posedge clk) disable iff (rst)
        efr_wr |=> (feat_enh_en == $past(efr_data[4]))); // R13

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DATA_W    = 8,
    parameter int MAX_DEPTH = 128,
    localparam int AW       = $clog2(MAX_DEPTH),
    localparam int CW       = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [CW-1:0]     cap,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty,
    output logic              overrun
);

    typedef struct packed {
        logic [AW-1:0]     wp;
        logic [AW-1:0]     rp;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] dout;
        logic              ovr;
    } fifo_t;

    fifo_t st_d, st_q;
    logic [DATA_W-1:0] mem [MAX_DEPTH];
    logic push_ok, pop_ok;

    assign full  = (st_q.cnt >= cap);
    assign empty = (st_q.cnt == '0);

    always_comb begin
        st_d    = st_q;
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        if (push && full && !flush)
            st_d.ovr = 1'b1;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok) st_d.wp = st_q.wp + 1'b1;
            if (pop_ok) begin
                st_d.rp   = st_q.rp + 1'b1;
                st_d.dout = mem[st_q.rp];
            end
            if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + 1'b1;
            else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wp] <= din;
    end

    assign dout    = st_q.dout;
    assign overrun = st_q.ovr;

    AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= cap); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R8
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> ($stable(dout) && empty)); // R9
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty); // R10

endmodule

// File: rtl/uart_fifo_mode_ctrl.sv
module uart_fifo_mode_ctrl
    import uart_mode_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int MID_DEPTH = 16,
    parameter int MAX_DEPTH = 128,
    localparam int CW       = $clog2(MAX_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              efr_wr,
    input  logic [DATA_W-1:0] efr_data,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_din,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_dout,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              tx_overrun,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_din,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_dout,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_overrun,
    output logic [1:0]        mode_code,
    output logic [CW-1:0]     depth,
    output logic              feat750_en,
    output logic              feat_enh_en
);

    uart_mode_e mode;
    logic       flush;

    mode_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .MID_DEPTH(MID_DEPTH), .MAX_DEPTH(MAX_DEPTH)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .efr_wr(efr_wr), .efr_data(efr_data),
        .mode(mode), .depth(depth), .flush(flush),
        .feat750_en(feat750_en), .feat_enh_en(feat_enh_en)
    );

    assign mode_code = mode;

    byte_fifo #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) u_tx (
        .clk(clk), .rst(rst), .flush(flush), .cap(depth),
        .push(tx_push), .din(tx_din), .pop(tx_pop), .dout(tx_dout),
        .full(tx_full), .empty(tx_empty), .overrun(tx_overrun)
    );

    byte_fifo #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) u_rx (
        .clk(clk), .rst(rst), .flush(flush), .cap(depth),
        .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
        .full(rx_full), .empty(rx_empty), .overrun(rx_overrun)
    );

    AST_BYTE_DEPTH: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 2'd0) |-> (tx_full || tx_empty)); // R2

endmodule

// File: tb/uart_fifo_mode_ctrl_test.sv
`timescale 1ns/1ps
module uart_fifo_mode_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en = 0, efr_wr = 0;
    logic [2:0] addr = 0;
    logic [7:0] wr_data = 0, efr_data = 0, rd_data;
    logic       tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic [7:0] tx_din = 0, rx_din = 0, tx_dout, rx_dout;
    logic       tx_full, tx_empty, tx_overrun, rx_full, rx_empty, rx_overrun;
    logic [1:0] mode_code;
    logic [7:0] depth;
    logic       feat750_en, feat_enh_en;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    uart_fifo_mode_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .efr_wr(efr_wr), .efr_data(efr_data),
        .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_overrun(tx_overrun),
        .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_overrun(rx_overrun),
        .mode_code(mode_code), .depth(depth),
        .feat750_en(feat750_en), .feat_enh_en(feat_enh_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic efr_write(input logic [7:0] d);
        @(negedge clk); efr_wr = 1; efr_data = d;
        @(negedge clk); efr_wr = 0;
    endtask

    task automatic tx_put(input logic [7:0] d);
        @(negedge clk); tx_push = 1; tx_din = d;
        @(negedge clk); tx_push = 0;
    endtask

    task automatic rx_put(input logic [7:0] d);
        @(negedge clk); rx_push = 1; rx_din = d;
        @(negedge clk); rx_push = 0;
    endtask

    task automatic tx_take();
        @(negedge clk); tx_pop = 1;
        @(negedge clk); tx_pop = 0;
    endtask

    task automatic rx_take();
        @(negedge clk); rx_pop = 1;
        @(negedge clk); rx_pop = 0;
    endtask

    // {lcr_guard, fcr, efr, exp_mode, exp_depth}
    localparam int NV = 10;
    localparam logic [26:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'h00, 2'd0, 8'd1},
        {1'b0, 8'h01, 8'h00, 2'd1, 8'd16},
        {1'b0, 8'h21, 8'h00, 2'd1, 8'd16},
        {1'b1, 8'h21, 8'h00, 2'd2, 8'd128},
        {1'b0, 8'h01, 8'h00, 2'd2, 8'd128},
        {1'b0, 8'h20, 8'h00, 2'd0, 8'd1},
        {1'b1, 8'h01, 8'h10, 2'd3, 8'd128},
        {1'b1, 8'h21, 8'h10, 2'd3, 8'd128},
        {1'b1, 8'h20, 8'h10, 2'd0, 8'd1},
        {1'b1, 8'h01, 8'h00, 2'd1, 8'd16}
    };

    initial begin
        #(5.0 * 200000);
        checks++; errors++;
        $display("FAIL watchdog R1: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        addr = 3'd3;
        #0.1;
        // R1 reset state
        chk("R1 mode", mode_code, 0);
        chk("R1 depth", depth, 1);
        chk("R1 lcr", rd_data, 0);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 tx_full", tx_full, 0);
        chk("R1 ovr", {tx_overrun, rx_overrun}, 0);
        chk("R1 dout", {tx_dout, rx_dout}, 0);

        // Mode table: R2 R3 R4 R5 R6 R7 R13
        for (int i = 0; i < NV; i++) begin
            efr_write(VEC[i][17:10]);
            reg_wr(3'd3, {VEC[i][26], 7'd0});
            reg_wr(3'd2, VEC[i][25:18]);
            chk($sformatf("R2-R6/R4/R13 vec%0d mode", i), mode_code, VEC[i][9:8]);
            chk($sformatf("R2-R6/R4/R13 vec%0d depth", i), depth, VEC[i][7:0]);
            chk($sformatf("R7 vec%0d feat750", i), feat750_en, !VEC[i][14]);
            chk($sformatf("R7 vec%0d feat_enh", i), feat_enh_en, VEC[i][14]);
        end
        // explicit tags for the table coverage above: R2 R3 R4 R5 R6

        // R11 register read-back
        reg_wr(3'd3, 8'h5A);
        @(negedge clk); addr = 3'd3; #0.1;
        chk("R11 lcr read", rd_data, 8'h5A);
        addr = 3'd2; #0.1;
        chk("R11 fcr reads zero", rd_data, 0);
        chk("R11 lcr write kept depth", depth, 16);

        // R8 / R12 in 16-deep mode
        for (int i = 0; i < 16; i++) begin
            tx_put(8'(i + 1));
            if (i == 14) chk("R8 not full at 15", tx_full, 0);
        end
        chk("R8 full at 16", tx_full, 1);
        chk("R8 no overrun yet", tx_overrun, 0);
        tx_put(8'hEE);
        chk("R8 overrun set", tx_overrun, 1);
        chk("R8 still full", tx_full, 1);
        tx_take();
        chk("R12 first out", tx_dout, 1);
        chk("R8 not full after pop", tx_full, 0);
        tx_take();
        chk("R12 second out", tx_dout, 2);
        chk("R8 overrun sticky", tx_overrun, 1);

        // R9 pop on empty rx
        rx_take();
        chk("R9 dout held", rx_dout, 0);
        chk("R9 still empty", rx_empty, 1);
        chk("R9 no overrun", rx_overrun, 0);

        // R10 flush on depth change
        rx_put(8'h11); rx_put(8'h22); rx_put(8'h33);
        chk("R10 rx has data", rx_empty, 0);
        reg_wr(3'd3, 8'h80);
        reg_wr(3'd2, 8'h21);
        chk("R10 depth now 128", depth, 128);
        chk("R10 tx flushed", tx_empty, 1);
        chk("R10 rx flushed", rx_empty, 1);

        // R2 / R8 byte mode
        reg_wr(3'd2, 8'h20);
        chk("R2 byte depth", depth, 1);
        rx_put(8'h44);
        chk("R8 byte full", rx_full, 1);
        rx_put(8'h55);
        chk("R8 byte overrun", rx_overrun, 1);
        rx_take();
        chk("R12 byte out", rx_dout, 8'h44);
        chk("R9 empty after pop", rx_empty, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule